// File: doc/BRIEF.md
# Prioritized Bus Ownership Arbiter

This block decides who drives a shared system bus. The processor owns the bus by default. Several external devices can claim it, and each device has its own request, grant and acknowledge lines. When the processor is in the middle of a transfer, a claim waits until that transfer ends. External devices outrank the processor, so a pending claim always takes the bus at the next transfer boundary. When several devices ask at the same time, the lowest-numbered one wins and the rest are served in turn afterwards.

A device keeps the bus for as long as it holds its request. Each requester is configured as either acknowledging or not. For an acknowledging requester, the grant is withdrawn if no acknowledge arrives within a set number of cycles. A requester that has timed out is skipped until it lowers its request. After every release, one dead cycle passes before the bus moves on, so that two drivers never overlap. The processor's output-enable is low whenever any device holds, or has just released, the bus.

Top module: `bus_arbiter`

## Requirements
- R1: During and right after reset, `cpu_oe` is 1 and every bit of `gnt` is 0.
- R2: While `cpu_active` is 1, a new request is not granted until a cycle in which `cpu_done` is 1. The grant appears on the clock edge that samples `cpu_done` high.
- R3: While `cpu_active` is 0, a pending request is granted on the first clock edge that samples it, and `cpu_oe` drops on that same edge.
- R4: Among simultaneous requests, the lowest index wins. `gnt` is the one-hot vector of the lowest set bit of the eligible requests.
- R5: At most one `gnt` bit is high at any time, and `cpu_oe` is never high while any `gnt` bit is high.
- R6: A requester whose bit in `ACK_MASK` is 0 keeps its grant for as long as it requests, with no acknowledge and for longer than `ACK_TIMEOUT` cycles.
- R7: A requester whose bit in `ACK_MASK` is 1 keeps its grant for as long as it requests, once its `ack` bit has been seen high.
- R8: A requester whose bit in `ACK_MASK` is 1 and that gives no acknowledge holds its grant for exactly `ACK_TIMEOUT` cycles and then loses it. It is not granted again until it has dropped its request for at least one cycle. Meanwhile the next eligible request is served.
- R9: When the owning device drops its request, its `gnt` bit falls on the following clock edge.
- R10: After a grant falls, one cycle follows with all `gnt` low and `cpu_oe` low. Only then is another grant issued or `cpu_oe` raised.
- R11: Requests left waiting are granted one after another, each after the gap cycle, before the processor gets the bus back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_active | input | 1 | Processor has a transfer in flight |
| cpu_done | input | 1 | Single-cycle pulse marking the end of a processor transfer |
| req | input | N_REQ | Bus request, one per external device |
| ack | input | N_REQ | Grant acknowledge, one per external device |
| gnt | output | N_REQ | Registered bus grant, one-hot or zero |
| cpu_oe | output | 1 | Registered enable for the processor's bus drivers |

## Verification
The bench builds the arbiter with four requesters, `ACK_MASK` = 4'b1010 and `ACK_TIMEOUT` = 4. With these values both requester kinds can be exercised, and every timeout fits within a few cycles. The small size allows every one of the 16 request patterns to be swept with an idle processor, and the expected winner is computed as the lowest set bit. Directed sequences then cover waiting on a busy processor, an acknowledged hold, a timeout with skip-until-drop, and a chain of back-to-back grants, each counted cycle by cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_CPU  = 2'd0,  // processor owns the bus
    ST_WAIT = 2'd1,  // grant issued, awaiting acknowledge
    ST_OWN  = 2'd2,  // device owns the bus
    ST_GAP  = 2'd3   // dead cycle after a release
  } arb_state_e;
endpackage

// File: rtl/arb_prio.sv
module arb_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] vec,
  output logic [N-1:0] hit
);
  // one-hot of the lowest set bit
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == 0) begin : g_first
      assign hit[i] = vec[0];
    end else begin : g_rest
      assign hit[i] = vec[i] & ~(|vec[i-1:0]);
    end
  end
endmodule

// File: rtl/arb_ack_timer.sv
module arb_ack_timer #(
  parameter int TIMEOUT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == CW'(TIMEOUT - 1));
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import arb_pkg::*;
#(
  parameter int               N_REQ       = 4,
  parameter int               ACK_TIMEOUT = 8,
  parameter logic [N_REQ-1:0] ACK_MASK    = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_active,
  input  logic             cpu_done,
  input  logic [N_REQ-1:0] req,
  input  logic [N_REQ-1:0] ack,
  output logic [N_REQ-1:0] gnt,
  output logic             cpu_oe
);
  arb_state_e       state_q, state_d;
  logic [N_REQ-1:0] gnt_q, gnt_d;
  logic [N_REQ-1:0] skip_q, skip_d;
  logic             oe_q, oe_d;
  logic [N_REQ-1:0] eligible, pick;
  logic             boundary, owner_req, owner_ack, expired;

  assign eligible  = req & ~skip_q;
  assign boundary  = cpu_done | ~cpu_active;
  assign owner_req = |(req & gnt_q);
  assign owner_ack = |(ack & gnt_q);

  arb_prio #(.N(N_REQ)) u_prio (
    .vec (eligible),
    .hit (pick)
  );

  arb_ack_timer #(.TIMEOUT(ACK_TIMEOUT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (state_q == ST_WAIT),
    .expired (expired)
  );

  always_comb begin
    state_d = state_q;
    gnt_d   = gnt_q;
    oe_d    = oe_q;
    skip_d  = skip_q & req;  // forget a timeout once its request drops
    unique case (state_q)
      ST_CPU: begin
        if (|eligible && boundary) begin
          gnt_d   = pick;
          oe_d    = 1'b0;
          state_d = (|(pick & ACK_MASK)) ? ST_WAIT : ST_OWN;
        end
      end
      ST_WAIT: begin
        if (!owner_req) begin
          gnt_d   = '0;
          state_d = ST_GAP;
        end else if (owner_ack) begin
          state_d = ST_OWN;
        end else if (expired) begin
          gnt_d   = '0;
          skip_d  = skip_d | gnt_q;
          state_d = ST_GAP;
        end
      end
      ST_OWN: begin
        if (!owner_req) begin
          gnt_d   = '0;
          state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        if (|eligible) begin
          gnt_d   = pick;
          state_d = (|(pick & ACK_MASK)) ? ST_WAIT : ST_OWN;
        end else begin
          oe_d    = 1'b1;
          state_d = ST_CPU;
        end
      end
      default: state_d = ST_CPU;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_CPU;
      gnt_q   <= '0;
      oe_q    <= 1'b1;
      skip_q  <= '0;
    end else begin
      state_q <= state_d;
      gnt_q   <= gnt_d;
      oe_q    <= oe_d;
      skip_q  <= skip_d;
    end
  end

  assign gnt    = gnt_q;
  assign cpu_oe = oe_q;

  a_r5_one_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  a_r5_oe_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(cpu_oe && |gnt));

  a_r2_hold_during_xfer: assert property (@(posedge clk) disable iff (rst)
    (cpu_oe && cpu_active && !cpu_done) |=> cpu_oe);

  a_r9_release_next: assert property (@(posedge clk) disable iff (rst)
    (|gnt && !(|(req & gnt))) |=> (gnt == '0));

  a_r10_no_direct_switch: assert property (@(posedge clk) disable iff (rst)
    (|gnt) |=> (gnt == $past(gnt) || gnt == '0));

  a_r10_oe_after_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_oe) |-> ($past(gnt) == '0));
endmodule

// File: tb/tb_bus_arbiter.sv
`timescale 1ns/1ps
module tb_bus_arbiter;
  localparam int         N  = 4;
  localparam int         TO = 4;
  localparam logic [3:0] AM = 4'b1010;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_active = 1'b0;
  logic         cpu_done = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] ack = '0;
  logic [N-1:0] gnt;
  logic         cpu_oe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bus_arbiter #(.N_REQ(N), .ACK_TIMEOUT(TO), .ACK_MASK(AM)) dut (
    .clk(clk), .rst(rst), .cpu_active(cpu_active), .cpu_done(cpu_done),
    .req(req), .ack(ack), .gnt(gnt), .cpu_oe(cpu_oe)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [N:0] act, input logic [N:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual={oe,gnt}=%b expected=%b", tag, act, exp);
    end
  endtask

  // drop all requests, then check the gap cycle and the return of the processor
  task automatic release_all(input string tag);
    req = '0; ack = '0;
    tick(); chk({tag, " R9/R10 gap"}, {cpu_oe, gnt}, {1'b0, 4'b0000});
    tick(); chk({tag, " R10 oe back"}, {cpu_oe, gnt}, {1'b1, 4'b0000});
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 in reset", {cpu_oe, gnt}, {1'b1, 4'b0000});
    tick(); tick();
    rst = 1'b0;
    tick();
    chk("R1 after reset", {cpu_oe, gnt}, {1'b1, 4'b0000});

    // R3/R4/R5 sweep of every request pattern, processor idle
    for (int p = 0; p < 16; p++) begin
      logic [3:0] pv, exp_g;
      pv    = 4'(p);
      exp_g = pv & (~pv + 4'd1);
      req = pv;
      tick();
      chk($sformatf("R3/R4/R5 pattern %b", pv), {cpu_oe, gnt},
          {(pv == 4'd0), exp_g});
      if (pv != 4'd0) release_all("R4 sweep");
      else req = '0;
    end

    // R2: busy processor delays the grant until the done pulse
    cpu_active = 1'b1;
    req = 4'b0001;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R2 wait for transfer end", {cpu_oe, gnt}, {1'b1, 4'b0000});
    end
    cpu_done = 1'b1;
    tick();
    chk("R2 grant at boundary", {cpu_oe, gnt}, {1'b0, 4'b0001});
    cpu_done = 1'b0;
    cpu_active = 1'b0;

    // R6: no-ack device holds beyond the timeout
    for (int k = 0; k < 2 * TO + 2; k++) tick();
    chk("R6 hold without ack", {cpu_oe, gnt}, {1'b0, 4'b0001});
    release_all("R6");

    // R7: ack-expected device with ack keeps the bus
    req = 4'b0010;
    tick();
    chk("R7 grant", {cpu_oe, gnt}, {1'b0, 4'b0010});
    ack = 4'b0010;
    for (int k = 0; k < 2 * TO + 2; k++) tick();
    chk("R7 hold with ack", {cpu_oe, gnt}, {1'b0, 4'b0010});
    release_all("R7");

    // R8: timeout withdraws, next eligible served, timed-out one skipped
    req = 4'b0110;
    tick();
    chk("R8 grant", {cpu_oe, gnt}, {1'b0, 4'b0010});
    for (int k = 1; k < TO; k++) begin
      tick();
      chk("R8 still waiting", {cpu_oe, gnt}, {1'b0, 4'b0010});
    end
    tick();
    chk("R8 withdrawn gap", {cpu_oe, gnt}, {1'b0, 4'b0000});
    tick();
    chk("R8 next served", {cpu_oe, gnt}, {1'b0, 4'b0100});
    req = 4'b0010;
    tick();
    chk("R8 gap", {cpu_oe, gnt}, {1'b0, 4'b0000});
    tick();
    chk("R8 skipped", {cpu_oe, gnt}, {1'b1, 4'b0000});
    tick();
    chk("R8 still skipped", {cpu_oe, gnt}, {1'b1, 4'b0000});
    req = 4'b0000;
    tick();
    req = 4'b0010;
    tick();
    chk("R8 eligible again", {cpu_oe, gnt}, {1'b0, 4'b0010});
    release_all("R8");

    // R11: pending requests served one after another
    req = 4'b1101;
    tick();
    chk("R11 first", {cpu_oe, gnt}, {1'b0, 4'b0001});
    req = 4'b1100;
    tick();
    chk("R11 gap 1", {cpu_oe, gnt}, {1'b0, 4'b0000});
    tick();
    chk("R11 second", {cpu_oe, gnt}, {1'b0, 4'b0100});
    req = 4'b1000;
    tick();
    chk("R11 gap 2", {cpu_oe, gnt}, {1'b0, 4'b0000});
    tick();
    chk("R11 third", {cpu_oe, gnt}, {1'b0, 4'b1000});
    release_all("R11");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule